// File: doc/BRIEF.md
# I2C 10-bit Target Address Matcher

This block decides whether an I2C target that uses 10-bit addressing is being selected. A byte engine outside the block shifts bits, stretches the clock and drives the acknowledge bit. After each START or repeated START, the engine passes each received byte to this block, together with the byte's position in the frame. This block compares those bytes against the configured 10-bit address. It returns one registered decision per address byte: acknowledge the header, report a full match, or refuse.

A write-direction header byte has the form `11110`, then the top two address bits, then a direction bit of 0. The block acknowledges this byte but does not report a match yet. The byte that follows is compared with the low eight address bits. If it is equal, the block reports a match in the write direction and remembers that it is selected.

A host that wants to read sends a repeated START and then a read-direction header, in which the direction bit is 1. The block selects itself on that header alone, but only if it is still remembered as selected. In that case it reports a second match, this time in the read direction. A STOP or any refused address byte clears the remembered state.

Top module: `i2c10_addr_match`

## Requirements
- R1: After reset, all four outputs are 0 and the target is not selected. A read header in the first frame after reset is therefore refused.
- R2: Index 0 is the first byte after a START. A byte at index 0 whose bits 7:3 are 11110, whose bits 2:1 equal address bits 9:8, and whose bit 0 is 0 makes `hdr_ack_o` pulse for one cycle, in the cycle after the byte. Neither `addr_match_o` nor `addr_nack_o` is asserted for that byte.
- R3: A byte at index 1 that directly follows an acknowledged write header, and that equals address bits 7:0, makes `addr_match_o` pulse in the next cycle. `addr_dir_o` becomes 0, and the target is remembered as selected.
- R4: A byte at index 1 after an acknowledged write header that differs from address bits 7:0 makes `addr_nack_o` pulse and clears the selected state.
- R5: A byte at index 0 whose upper seven bits do not match (a wrong prefix or wrong top address bits) makes `addr_nack_o` pulse and clears the selected state, whatever its bit 0.
- R6: A matching read header (bit 0 = 1) at index 0 while the target is selected makes `addr_match_o` pulse with `addr_dir_o` = 1. `hdr_ack_o` stays 0. This works after a repeated START, with no second low byte.
- R7: A matching read header while the target is not selected makes `addr_nack_o` pulse.
- R8: A STOP clears the selected state, so a read header after a later START is refused.
- R9: Some bytes produce no output at all: bytes at index 2 or above, a byte at index 1 that does not follow an acknowledged write header, and bytes received outside a frame (after a STOP or a refusal, before the next START).
- R10: A START or STOP in the same cycle as a byte takes priority, and the byte is discarded. A START keeps the selected state; a STOP clears it.
- R11: `addr_dir_o` keeps the direction of the last match until the next match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr_i | input | 10 | Configured 10-bit target address |
| start_i | input | 1 | One-cycle pulse: START or repeated START seen |
| stop_i | input | 1 | One-cycle pulse: STOP seen |
| byte_valid_i | input | 1 | A received byte is present this cycle |
| byte_idx_i | input | 4 | Position of the byte since the last START (0 = first) |
| byte_i | input | 8 | Received byte, bit 0 is the direction bit of a header |
| hdr_ack_o | output | 1 | Pulse: acknowledge the first address byte |
| addr_match_o | output | 1 | Pulse: full address match |
| addr_nack_o | output | 1 | Pulse: refuse the address byte |
| addr_dir_o | output | 1 | Direction of the last match, 1 = read |

## Verification
The bench sends every header value and every low-byte value for several own addresses. A decoder that compared the wrong bits or ignored the direction bit would therefore produce an acknowledge or refusal on some byte where the arithmetic model predicts the other.

After each full write match, a repeated START with a read header must be selected. After each refusal, the same header must be refused. A design that lost its selected state at a repeated START, or kept it after a STOP or after a wrong address, would get these wrong.

Further cases cover:
- bytes that arrive at the same time as START or STOP, which must be discarded;
- data bytes and misplaced index-1 bytes, which must stay silent;
- the direction output, which must hold across a later header acknowledge.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,
      PH_HDR  = 2'd1,
      PH_LOW  = 2'd2,
      PH_DATA = 2'd3
   } phase_e;

   typedef struct packed {
      logic tag_ok;
      logic rd;
   } hdr_info_t;
endpackage

// File: rtl/i2c10_hdr_decode.sv
module i2c10_hdr_decode
   import i2c10_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int PREFIX_W = 5,
   parameter logic [PREFIX_W-1:0] PREFIX = 5'b11110
) (
   input  logic [7:0]        byte_i,
   input  logic [ADDR_W-9:0] own_hi_i,
   output hdr_info_t         hdr_o
);
   localparam int HI_W  = ADDR_W - 8;
   localparam int TAG_W = PREFIX_W + HI_W;

   generate
      if (TAG_W + 1 != 8) begin : g_bad_width
         $error("header tag plus direction bit must fill one byte");
      end
   endgenerate

   logic [TAG_W-1:0] want;
   logic [TAG_W-1:0] bit_eq;

   assign want = {PREFIX, own_hi_i};

   genvar gi;
   generate
      for (gi = 0; gi < TAG_W; gi++) begin : g_tag_bit
         assign bit_eq[gi] = byte_i[gi+1] ~^ want[gi];
      end
   endgenerate

   assign hdr_o.tag_ok = &bit_eq;
   assign hdr_o.rd     = byte_i[0];
endmodule

// File: rtl/i2c10_low_cmp.sv
module i2c10_low_cmp #(
   parameter int LOW_W = 8
) (
   input  logic [LOW_W-1:0] byte_i,
   input  logic [LOW_W-1:0] own_lo_i,
   output logic             eq_o
);
   generate
      if (LOW_W != 8) begin : g_bad_low
         $error("low address part must be one byte");
      end
   endgenerate

   logic [LOW_W-1:0] bit_eq;

   genvar gi;
   generate
      for (gi = 0; gi < LOW_W; gi++) begin : g_low_bit
         assign bit_eq[gi] = byte_i[gi] ~^ own_lo_i[gi];
      end
   endgenerate

   assign eq_o = &bit_eq;
endmodule

// File: rtl/i2c10_seq.sv
module i2c10_seq
   import i2c10_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             byte_valid_i,
   input  logic [IDX_W-1:0] byte_idx_i,
   input  hdr_info_t        hdr_i,
   input  logic             low_eq_i,
   output logic             hdr_ack_o,
   output logic             addr_match_o,
   output logic             addr_nack_o,
   output logic             addr_dir_o
);
   generate
      if (IDX_W < 2) begin : g_bad_idx
         $error("byte index must count at least to 2");
      end
   endgenerate

   localparam logic [IDX_W-1:0] IDX_HDR = IDX_W'(0);
   localparam logic [IDX_W-1:0] IDX_LOW = IDX_W'(1);

   phase_e phase_q;
   logic   selected_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q      <= PH_OFF;
         selected_q   <= 1'b0;
         hdr_ack_o    <= 1'b0;
         addr_match_o <= 1'b0;
         addr_nack_o  <= 1'b0;
         addr_dir_o   <= 1'b0;
      end else begin
         hdr_ack_o    <= 1'b0;
         addr_match_o <= 1'b0;
         addr_nack_o  <= 1'b0;
         if (stop_i) begin
            phase_q    <= PH_OFF;
            selected_q <= 1'b0;
         end else if (start_i) begin
            phase_q <= PH_HDR;
         end else if (byte_valid_i) begin
            if (phase_q == PH_HDR && byte_idx_i == IDX_HDR) begin
               if (hdr_i.tag_ok && !hdr_i.rd) begin
                  hdr_ack_o <= 1'b1;
                  phase_q   <= PH_LOW;
               end else if (hdr_i.tag_ok && selected_q) begin
                  addr_match_o <= 1'b1;
                  addr_dir_o   <= 1'b1;
                  phase_q      <= PH_DATA;
               end else begin
                  addr_nack_o <= 1'b1;
                  selected_q  <= 1'b0;
                  phase_q     <= PH_OFF;
               end
            end else if (phase_q == PH_LOW && byte_idx_i == IDX_LOW) begin
               if (low_eq_i) begin
                  addr_match_o <= 1'b1;
                  addr_dir_o   <= 1'b0;
                  selected_q   <= 1'b1;
                  phase_q      <= PH_DATA;
               end else begin
                  addr_nack_o <= 1'b1;
                  selected_q  <= 1'b0;
                  phase_q     <= PH_OFF;
               end
            end
         end
      end
   end

   // R2 R3 R4: one outcome per byte at most
   p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({hdr_ack_o, addr_match_o, addr_nack_o}) <= 1);

   // R6: a read-direction match needs a selection made earlier
   p_read_needs_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_match_o && addr_dir_o) |-> $past(selected_q));

   // R8: STOP forgets the selection
   p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !selected_q);

   // R10: events override a byte in the same cycle
   p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i || stop_i) |=> !(hdr_ack_o || addr_match_o || addr_nack_o));

   // R11: direction only moves with a match
   p_dir_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_match_o |-> $stable(addr_dir_o));

   // R4 R5: refusal leaves the target unselected
   p_nack_unsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      addr_nack_o |-> !selected_q);

   // R9: nothing answers a byte outside the address phases
   p_silent_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_i && !start_i && !stop_i && byte_idx_i > IDX_LOW)
         |=> !(hdr_ack_o || addr_match_o || addr_nack_o));
endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
   import i2c10_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int PREFIX_W = 5,
   parameter logic [PREFIX_W-1:0] PREFIX = 5'b11110,
   parameter int IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              byte_valid_i,
   input  logic [IDX_W-1:0]  byte_idx_i,
   input  logic [7:0]        byte_i,
   output logic              hdr_ack_o,
   output logic              addr_match_o,
   output logic              addr_nack_o,
   output logic              addr_dir_o
);
   localparam int LOW_W = 8;

   generate
      if (ADDR_W <= LOW_W) begin : g_bad_addr
         $error("address must be wider than one byte");
      end
   endgenerate

   hdr_info_t hdr;
   logic      low_eq;

   i2c10_hdr_decode #(
      .ADDR_W  (ADDR_W),
      .PREFIX_W(PREFIX_W),
      .PREFIX  (PREFIX)
   ) u_hdr (
      .byte_i  (byte_i),
      .own_hi_i(own_addr_i[ADDR_W-1:LOW_W]),
      .hdr_o   (hdr)
   );

   i2c10_low_cmp #(
      .LOW_W(LOW_W)
   ) u_low (
      .byte_i  (byte_i),
      .own_lo_i(own_addr_i[LOW_W-1:0]),
      .eq_o    (low_eq)
   );

   i2c10_seq #(
      .IDX_W(IDX_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .stop_i      (stop_i),
      .byte_valid_i(byte_valid_i),
      .byte_idx_i  (byte_idx_i),
      .hdr_i       (hdr),
      .low_eq_i    (low_eq),
      .hdr_ack_o   (hdr_ack_o),
      .addr_match_o(addr_match_o),
      .addr_nack_o (addr_nack_o),
      .addr_dir_o  (addr_dir_o)
   );
endmodule

// File: tb/i2c10_addr_match_tb.sv
module i2c10_addr_match_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] own_addr = 10'h000;
   logic       start = 1'b0;
   logic       stop = 1'b0;
   logic       bv = 1'b0;
   logic [3:0] bidx = 4'd0;
   logic [7:0] bdat = 8'h00;
   logic       ack, match, nack, dir;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit m_dir = 1'b0;

   always #5 clk = ~clk;

   i2c10_addr_match dut_i (
      .clk(clk), .rst_n(rst_n), .own_addr_i(own_addr),
      .start_i(start), .stop_i(stop), .byte_valid_i(bv),
      .byte_idx_i(bidx), .byte_i(bdat),
      .hdr_ack_o(ack), .addr_match_o(match), .addr_nack_o(nack),
      .addr_dir_o(dir)
   );

   task automatic drive(input logic st, input logic sp, input logic v,
                        input logic [3:0] ix, input logic [7:0] d);
      @(negedge clk);
      start = st; stop = sp; bv = v; bidx = ix; bdat = d;
      @(negedge clk);
      start = 1'b0; stop = 1'b0; bv = 1'b0;
   endtask

   task automatic expect_out(input logic ea, input logic em, input logic en,
                             input logic ed, input string tag);
      checks++;
      if ({ack, match, nack, dir} !== {ea, em, en, ed}) begin
         failures++;
         $display("FAIL %s: ack/match/nack/dir got %b%b%b%b exp %b%b%b%b",
                  tag, ack, match, nack, dir, ea, em, en, ed);
      end
   endtask

   function automatic logic [7:0] hdr_of(input logic [9:0] a, input logic rd);
      return {5'b11110, a[9:8], rd};
   endfunction

   task automatic full_write_match(input string tag);
      drive(1, 0, 0, 0, 8'h00);
      drive(0, 0, 1, 0, hdr_of(own_addr, 1'b0));
      expect_out(1, 0, 0, m_dir, {tag, " hdr R2"});
      drive(0, 0, 1, 1, own_addr[7:0]);
      m_dir = 1'b0;
      expect_out(0, 1, 0, 0, {tag, " low R3"});
   endtask

   initial begin
      logic [9:0] addrs [4];
      addrs[0] = 10'h000; addrs[1] = 10'h2A5; addrs[2] = 10'h3FF; addrs[3] = 10'h15A;

      repeat (3) @(negedge clk);
      expect_out(0, 0, 0, 0, "R1 reset outputs");
      rst_n = 1'b1;
      drive(1, 0, 0, 0, 8'h00);
      drive(0, 0, 1, 0, hdr_of(own_addr, 1'b1));
      expect_out(0, 0, 1, 0, "R1 R7 read hdr after reset");

      for (int k = 0; k < 4; k++) begin
         own_addr = addrs[k];
         drive(0, 1, 0, 0, 8'h00);
         // header sweep (target never selected here)
         for (int b = 0; b < 256; b++) begin
            logic [7:0] bb;
            logic ok;
            bb = 8'(b);
            ok = (bb[7:3] == 5'b11110) && (bb[2:1] == own_addr[9:8]);
            drive(1, 0, 0, 0, 8'h00);
            drive(0, 0, 1, 0, bb);
            if (ok && !bb[0]) expect_out(1, 0, 0, m_dir, "R2 header sweep");
            else if (ok)      expect_out(0, 0, 1, m_dir, "R7 read hdr unselected");
            else              expect_out(0, 0, 1, m_dir, "R5 header mismatch");
         end
         // low byte sweep with repeated-START read follow-up
         for (int v = 0; v < 256; v++) begin
            logic [7:0] vv;
            vv = 8'(v);
            drive(0, 1, 0, 0, 8'h00);
            drive(1, 0, 0, 0, 8'h00);
            drive(0, 0, 1, 0, hdr_of(own_addr, 1'b0));
            expect_out(1, 0, 0, m_dir, "R2 write hdr");
            drive(0, 0, 1, 1, vv);
            if (vv == own_addr[7:0]) begin
               m_dir = 1'b0;
               expect_out(0, 1, 0, 0, "R3 low match");
               drive(0, 0, 1, 2, 8'hA5);
               expect_out(0, 0, 0, 0, "R9 data byte silent");
               drive(1, 0, 0, 0, 8'h00);
               drive(0, 0, 1, 0, hdr_of(own_addr, 1'b1));
               m_dir = 1'b1;
               expect_out(0, 1, 0, 1, "R6 read after repeated START");
               drive(0, 0, 1, 1, own_addr[7:0]);
               expect_out(0, 0, 0, 1, "R9 idx1 after read match silent");
            end else begin
               expect_out(0, 0, 1, m_dir, "R4 low mismatch");
               drive(1, 0, 0, 0, 8'h00);
               drive(0, 0, 1, 0, hdr_of(own_addr, 1'b1));
               expect_out(0, 0, 1, m_dir, "R4 selection cleared");
            end
         end
         // STOP clears selection
         full_write_match("R8 setup");
         drive(0, 1, 0, 0, 8'h00);
         drive(1, 0, 0, 0, 8'h00);
         drive(0, 0, 1, 0, hdr_of(own_addr, 1'b1));
         expect_out(0, 0, 1, m_dir, "R8 read after STOP");
         // mismatching header clears selection
         full_write_match("R5 setup");
         drive(1, 0, 0, 0, 8'h00);
         drive(0, 0, 1, 0, 8'h50);
         expect_out(0, 0, 1, m_dir, "R5 other address");
         drive(1, 0, 0, 0, 8'h00);
         drive(0, 0, 1, 0, hdr_of(own_addr, 1'b1));
         expect_out(0, 0, 1, m_dir, "R5 read refused after mismatch");
         // START with byte in same cycle
         full_write_match("R10 setup");
         drive(1, 0, 1, 0, hdr_of(own_addr, 1'b1));
         expect_out(0, 0, 0, m_dir, "R10 START beats byte");
         drive(0, 0, 1, 0, hdr_of(own_addr, 1'b1));
         m_dir = 1'b1;
         expect_out(0, 1, 0, 1, "R10 START kept selection R6");
         // dir holds across header ack
         drive(1, 0, 0, 0, 8'h00);
         drive(0, 0, 1, 0, hdr_of(own_addr, 1'b0));
         expect_out(1, 0, 0, 1, "R11 dir held on hdr ack");
         // STOP with byte in same cycle
         drive(0, 0, 1, 1, own_addr[7:0]);
         m_dir = 1'b0;
         expect_out(0, 1, 0, 0, "R3 match before R10 stop");
         drive(0, 1, 1, 0, hdr_of(own_addr, 1'b1));
         expect_out(0, 0, 0, 0, "R10 STOP beats byte");
         drive(0, 0, 1, 0, hdr_of(own_addr, 1'b0));
         expect_out(0, 0, 0, 0, "R9 byte outside frame");
         drive(1, 0, 0, 0, 8'h00);
         drive(0, 0, 1, 1, own_addr[7:0]);
         expect_out(0, 0, 0, 0, "R9 idx1 without header");
         drive(0, 0, 1, 0, hdr_of(own_addr, 1'b1));
         expect_out(0, 0, 1, 0, "R10 STOP cleared selection");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, got hung exp done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule